// File: doc/BRIEF.md
# Cycle and Event Performance Counter Block

This block counts activity for performance analysis. It holds one cycle counter and two event counters, each 32 bits wide. A single packed control word sets how they behave. Each event counter takes its input from a vector of single-cycle event strobes. An 8-bit code in the control word selects one strobe for each counter. A code that names no strobe makes that counter hold still, and this includes the reserved idle code 0x20.

Software reaches the block through one indexed register port. Index 0 is the control word, index 1 the cycle counter, index 2 event counter 0 and index 3 event counter 1. Writes take effect on the clock edge. Reads are combinational from the selected register. When a counter wraps past its all-ones value it sets a sticky overflow flag. The interrupt output is high while any flag is set together with its matching enable.

Top module: `evt_perf_monitor`

## Requirements
- R1: After reset all four registers read 0 and `irq` is low.
- R2: Register index 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. Every counter reads back the value written to it. Control bits 1, 2, 7, 11 and 31:28 always read 0.
- R3: While control bit 0 (enable) is 0, none of the three counters changes, whatever the event strobes do.
- R4: While enable is 1 and control bit 3 is 0, the cycle counter increments once per clock.
- R5: While enable and control bit 3 are both 1, the cycle counter increments once per 64 clocks. The first increment comes on the 64th clock after a write that sets bit 2.
- R6: Event counter 0 increments on every clock where strobe number `ctrl[27:20]` is high. Event counter 1 does the same with `ctrl[19:12]`. A code of 20 or more, including 0x20, counts nothing.
- R7: Writing 1 to control bit 1 clears both event counters. Writing 1 to bit 2 clears the cycle counter and the prescaler.
- R8: When a counter wraps from 0xFFFFFFFF to 0 it sets its overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter.
- R9: Writing 1 to a flag bit clears that flag. Writing 0 to it leaves it unchanged.
- R10: `irq` is high exactly when some flag is set while its enable is set. Bit 4 enables bit 8, bit 5 enables bit 9 and bit 6 enables bit 10.
- R11: A write to a counter wins over an increment in the same cycle, and loading a value this way never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_idx | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| evt_strobe | input | 20 | Single-cycle event strobes, bit n is event code n |
| irq | output | 1 | Overflow interrupt |

## Verification
The cycle counter is run free-running and prescaled.

- A reading of 0 after 63 clocks and 1 after 64 clocks separates a correct divide-by-64 from an off-by-one prescaler.

The two event counters see interleaved strobe patterns: one every third clock and one on odd clocks. These use codes 7 and 0x13.

- Different counts on the two counters show that each selector picks its own strobe.
- Using code 0x13 exercises the highest valid code.

With every strobe held high:

- An idle selector code must count nothing.
- A cleared enable must stop all three counters.

Counters preloaded near all-ones are used to check two things:

- whether each wrap reaches the correct flag bit and the interrupt mask;
- whether a write that coincides with an increment takes priority.

// File: rtl/evt_perf_monitor.sv
module evt_perf_monitor #(
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 20,
  parameter int PRESCALE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_idx,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  output logic             irq
);
  localparam int PS_W  = $clog2(PRESCALE);
  localparam int SEL_W = 8;
  localparam int SEL_N = 1 << SEL_W;

  logic             ctl_en, ctl_div;
  logic [2:0]       ctl_ie, ovf;
  logic [SEL_W-1:0] sel0, sel1;
  logic [PS_W-1:0]  ps_cnt;
  logic [CNT_W-1:0] cyc_cnt, ev_cnt0, ev_cnt1;

  wire ctl_wr  = reg_wr && reg_idx == 2'd0;
  wire cyc_wr  = reg_wr && reg_idx == 2'd1;
  wire ev0_wr  = reg_wr && reg_idx == 2'd2;
  wire ev1_wr  = reg_wr && reg_idx == 2'd3;
  wire ev_clr  = ctl_wr && reg_wdata[1];
  wire cyc_clr = ctl_wr && reg_wdata[2];

  wire [SEL_N-1:0] evt_ext = {{(SEL_N-NUM_EVT){1'b0}}, evt_strobe};
  wire ps_tick = ps_cnt == PS_W'(PRESCALE-1);
  wire cyc_inc = ctl_en && (!ctl_div || ps_tick);
  wire ev0_inc = ctl_en && evt_ext[sel0];
  wire ev1_inc = ctl_en && evt_ext[sel1];

  wire [2:0] wrap = {cyc_inc && (&cyc_cnt) && !cyc_wr && !cyc_clr,
                     ev1_inc && (&ev_cnt1) && !ev1_wr && !ev_clr,
                     ev0_inc && (&ev_cnt0) && !ev0_wr && !ev_clr};
  wire [2:0] w1c  = ctl_wr ? reg_wdata[10:8] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_div <= 1'b0; ctl_ie <= '0;
      sel0 <= '0; sel1 <= '0; ovf <= '0;
    end else begin
      if (ctl_wr) begin
        ctl_en  <= reg_wdata[0];
        ctl_div <= reg_wdata[3];
        ctl_ie  <= reg_wdata[6:4];
        sel1    <= reg_wdata[19:12];
        sel0    <= reg_wdata[27:20];
      end
      ovf <= (ovf & ~w1c) | wrap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cyc_clr)
      ps_cnt <= '0;
    else if (ctl_en && ctl_div)
      ps_cnt <= ps_tick ? '0 : ps_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cyc_cnt <= '0;
    else if (cyc_wr)  cyc_cnt <= reg_wdata;
    else if (cyc_clr) cyc_cnt <= '0;
    else if (cyc_inc) cyc_cnt <= cyc_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ev_cnt0 <= '0;
    else if (ev0_wr)  ev_cnt0 <= reg_wdata;
    else if (ev_clr)  ev_cnt0 <= '0;
    else if (ev0_inc) ev_cnt0 <= ev_cnt0 + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ev_cnt1 <= '0;
    else if (ev1_wr)  ev_cnt1 <= reg_wdata;
    else if (ev_clr)  ev_cnt1 <= '0;
    else if (ev1_inc) ev_cnt1 <= ev_cnt1 + 1'b1;
  end

  wire [CNT_W-1:0] ctl_view = CNT_W'({4'b0, sel0, sel1, 1'b0, ovf, 1'b0,
                                      ctl_ie, ctl_div, 2'b00, ctl_en});

  always_comb begin
    case (reg_idx)
      2'd0:    reg_rdata = ctl_view;
      2'd1:    reg_rdata = cyc_cnt;
      2'd2:    reg_rdata = ev_cnt0;
      default: reg_rdata = ev_cnt1;
    endcase
  end

  assign irq = |(ovf & ctl_ie);
endmodule

// File: rtl/evt_perf_monitor_chk.sv
module evt_perf_monitor_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_idx,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             irq,
  input logic             ctl_en,
  input logic [2:0]       ovf,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic [CNT_W-1:0] ev_cnt0,
  input logic [CNT_W-1:0] ev_cnt1
);
  wire ctl_wr = reg_wr && reg_idx == 2'd0;

  // R3
  en_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !reg_wr) |=> ($stable(cyc_cnt) && $stable(ev_cnt0) && $stable(ev_cnt1)));

  // R11
  cyc_wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 2'd1) |=> cyc_cnt == $past(reg_wdata));

  // R11
  ev0_wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 2'd2) |=> ev_cnt0 == $past(reg_wdata));

  // R7
  ev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[1]) |=> (ev_cnt0 == '0 && ev_cnt1 == '0));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[0] && !(ctl_wr && reg_wdata[8])) |=> ovf[0]);

  // R8
  cyc_wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cyc_cnt) == '1 && cyc_cnt == '0 && !$past(reg_wr)) |-> ovf[2]);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf != 3'b000));
endmodule

bind evt_perf_monitor evt_perf_monitor_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
  .reg_wdata(reg_wdata), .irq(irq), .ctl_en(ctl_en), .ovf(ovf),
  .cyc_cnt(cyc_cnt), .ev_cnt0(ev_cnt0), .ev_cnt1(ev_cnt1)
);

// File: tb/evt_perf_monitor_tb_top.sv
`timescale 1ns/1ps
module evt_perf_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [19:0] evt = '0;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_perf_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt), .irq(irq)
  );

  localparam logic [31:0] C = 32'h0070_5011;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] i, output logic [31:0] v);
    reg_idx = i;
    #1;
    v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v); chk("R1 reg", v, 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_rw();
    logic [31:0] v;
    wr(2'd1, 32'h1234_5678); wr(2'd2, 32'hA5A5_0001); wr(2'd3, 32'h0F0F_F0F0);
    rd(2'd1, v); chk("R2 cyc", v, 32'h1234_5678);
    rd(2'd2, v); chk("R2 ev0", v, 32'hA5A5_0001);
    rd(2'd3, v); chk("R2 ev1", v, 32'h0F0F_F0F0);
    wr(2'd0, 32'hFFFF_F8F8);
    rd(2'd0, v); chk("R2 ctrl", v, 32'h0FFF_F078);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] c0, e0, e1, v;
    rd(2'd1, c0); rd(2'd2, e0); rd(2'd3, e1);
    evt = '1;
    repeat (20) @(negedge clk);
    evt = '0;
    rd(2'd1, v); chk("R3 cyc", v, c0);
    rd(2'd2, v); chk("R3 ev0", v, e0);
    rd(2'd3, v); chk("R3 ev1", v, e1);
  endtask

  task automatic t_cycle();
    logic [31:0] v;
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R11 cyc load", v, 32'h0);
    repeat (10) @(negedge clk);
    rd(2'd1, v); chk("R4 cyc", v, 32'd10);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(2'd0, 32'h0000_000D);
    rd(2'd1, v); chk("R7 cyc clr", v, 32'h0);
    repeat (63) @(negedge clk);
    rd(2'd1, v); chk("R5 at 63", v, 32'd0);
    @(negedge clk);
    rd(2'd1, v); chk("R5 at 64", v, 32'd1);
    repeat (64) @(negedge clk);
    rd(2'd1, v); chk("R5 at 128", v, 32'd2);
  endtask

  task automatic t_event();
    logic [31:0] v;
    wr(2'd0, 32'h0071_3003);
    rd(2'd2, v); chk("R7 ev0 clr", v, 32'h0);
    for (int i = 0; i < 16; i++) begin
      evt = '0;
      evt[7]  = (i % 3) == 0;
      evt[19] = (i % 2) == 1;
      @(negedge clk);
    end
    evt = '0;
    rd(2'd2, v); chk("R6 ev0", v, 32'd6);
    rd(2'd3, v); chk("R6 ev1", v, 32'd8);
    wr(2'd0, 32'h0201_3001);
    evt = '1;
    repeat (10) @(negedge clk);
    evt = '0;
    rd(2'd2, v); chk("R6 idle code", v, 32'd6);
    rd(2'd3, v); chk("R6 ev1 all", v, 32'd18);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(2'd0, 32'h0);
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, C);
    wr(2'd1, 32'hFFFF_FFFD);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R8 cyc flag", v, C | 32'h400);
    chk("R10 masked", 32'(irq), 32'h0);
    evt[7] = 1'b1;
    repeat (2) @(negedge clk);
    evt[7] = 1'b0; evt[5] = 1'b1;
    @(negedge clk);
    evt = '0;
    rd(2'd0, v); chk("R8 all flags", v, C | 32'h700);
    rd(2'd2, v); chk("R8 ev0 wrap", v, 32'h0);
    rd(2'd3, v); chk("R8 ev1 wrap", v, 32'h0);
    chk("R10 irq", 32'(irq), 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(2'd0, C | 32'h100);
    rd(2'd0, v); chk("R9 clear one", v, C | 32'h600);
    chk("R10 irq drop", 32'(irq), 32'h0);
    wr(2'd0, C);
    rd(2'd0, v); chk("R9 zero keeps", v, C | 32'h600);
    wr(2'd0, C | 32'h40);
    chk("R10 cyc ie", 32'(irq), 32'h1);
    wr(2'd0, C | 32'h600);
    rd(2'd0, v); chk("R9 clear rest", v, C);
    chk("R10 irq low", 32'(irq), 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    evt[7] = 1'b1;
    wr(2'd2, 32'h100);
    rd(2'd2, v); chk("R11 ev0 write", v, 32'h100);
    @(negedge clk);
    rd(2'd2, v); chk("R11 inc after", v, 32'h101);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R11 no flag", v, C);
    @(negedge clk);
    rd(2'd0, v); chk("R8 wrap after load", v, C | 32'h100);
    evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rw();
    t_disable();
    t_cycle();
    t_prescale();
    t_event();
    t_overflow();
    t_w1c();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule